// File: doc/BRIEF.md
# Transmit FIFO Chunked Burst Reader

This block drains write data from a user-side transmit FIFO whose words are 512 bits wide, one 512-byte sector at a time. A sector is eight consecutive FIFO words. The block reads the FIFO's fill level to decide when a sector can be fetched. It tracks how many sectors of the current transfer are still outstanding. Every word it reads is forwarded downstream with a valid strobe.

The transfer length is given in sectors. The block cuts it into device commands of at most `CHUNK_SECT` sectors (128 KB by default). The last command may be shorter. A command pulse is raised only once every sector of that command has been pulled from the FIFO. The block then holds off all further reads until the downstream side acknowledges the command. Busy falls after the acknowledge of the final command.

When the FIFO already holds enough data, bursts run back-to-back. On the eighth beat of a sector, the block checks for two things: at least one more sector belongs to the current command, and the fill level shows at least sixteen words. If both hold, the read enable stays high into the next sector with no idle cycle.

Top module: `txfifo_chunk_reader`

## Requirements
- R1: While reset is low, `xfer_busy`, `fifo_rd_en`, `out_valid` and `cmd_issue` are all 0.
- R2: A `xfer_start` sampled while idle with a non-zero `xfer_sectors` raises `xfer_busy` on the next cycle. A start with zero length, or any start while busy, has no effect on busy, on the reads or on the total transferred.
- R3: `fifo_rd_en` rises only in the cycle after the fill level seen at the clock edge was at least 8 words (bits [15:3] non-zero). The current command must still be missing sectors and must not be awaiting its acknowledge. When all three conditions hold and no burst is running, it rises on that edge.
- R4: Each stretch of `fifo_rd_en` high lasts a non-zero multiple of 8 cycles.
- R5: On the 8th beat of a sector, the read enable stays high into the next cycle if and only if two conditions hold: another sector of the current command remains, and the fill level is at least 16 words (bits [15:4] non-zero).
- R6: `out_valid` equals `fifo_rd_en` delayed by one cycle. `out_data` carries the FIFO word read by that enable.
- R7: Command sizes are min(remaining, `CHUNK_SECT`) in order. `cmd_issue` is a one-cycle pulse in the cycle right after the last read of the command, with `cmd_sectors` equal to that size.
- R8: From `cmd_issue` until `cmd_done` is sampled, no FIFO read occurs. A `cmd_done` outside this wait has no effect.
- R9: `xfer_busy` falls in the cycle after the last command's `cmd_done` is sampled. A transfer of N sectors forwards exactly 8·N words. While idle, neither reads nor command pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Start request, sampled while idle |
| xfer_sectors | input | LEN_W | Transfer length in 512-byte sectors |
| xfer_busy | output | 1 | Transfer in progress |
| fifo_level | input | CNT_W | Words currently stored in the transmit FIFO |
| fifo_rd_en | output | 1 | FIFO read enable |
| fifo_rd_data | input | DATA_W | FIFO read data, valid the cycle after a read |
| out_valid | output | 1 | Forwarded word valid |
| out_data | output | DATA_W | Forwarded word |
| cmd_issue | output | 1 | One-cycle pulse: a command's data is fully gathered |
| cmd_sectors | output | CHK_W | Sector count of the command being issued |
| cmd_done | input | 1 | Acknowledge that the issued command has completed |

## Verification
The hardest case to reach from the ports is the continuation decision at its edges. One such edge is a sector boundary where the fill level sits between 8 and 15 words. Another is the final sector of a command while the FIFO is well stocked, which must still stop the burst. The bench fills the FIFO model at random rates from 10 % to 100 % per cycle, so the level hovers around both thresholds. It uses a reduced command size so that command boundaries occur often. A reference model predicts every continuation from the level and remaining sectors seen at the eighth beat. Directed runs add an exact-multiple length, a one-sector transfer, a start while busy, a zero-length start and an acknowledge pulsed during gathering.

// File: rtl/txcr_pkg.sv
// Shared types for the transmit FIFO chunked burst reader.
package txcr_pkg;
    // Command-level phase of a transfer.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_GATHER = 2'd1,
        PH_ISSUE  = 2'd2,
        PH_WAIT   = 2'd3
    } phase_e;
endpackage

// File: rtl/txcr_burst_engine.sv
// Sector burst engine: asserts the FIFO read enable for whole sectors of
// BEATS words. It starts when the level shows one full sector. On the last
// beat it continues without a gap when another sector is wanted and the
// level shows two sectors, which covers the word being read in that cycle.
// Assumes BEATS is a power of two and the level lags reads by at most one
// cycle.
module txcr_burst_engine #(
    parameter int CNT_W = 16,
    parameter int BEATS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gather_ok,
    input  logic             more_in_chunk,
    input  logic [CNT_W-1:0] fifo_level,
    output logic             rd_en,
    output logic             sector_done
);
    localparam int BEAT_W = $clog2(BEATS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    logic              in_burst_q;
    logic [BEAT_W-1:0] beat_q;
    logic              start_ok;
    logic              cont_ok;

    // Threshold decodes on the fill level.
    assign start_ok    = fifo_level >= CNT_W'(BEATS);
    assign cont_ok     = fifo_level >= CNT_W'(2 * BEATS);
    assign rd_en       = in_burst_q;
    assign sector_done = in_burst_q && (beat_q == LAST_BEAT);

    // Burst state and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_burst_q <= 1'b0;
            beat_q     <= '0;
        end else if (in_burst_q) begin
            if (beat_q == LAST_BEAT) begin
                beat_q     <= '0;
                in_burst_q <= more_in_chunk && cont_ok;
            end else begin
                beat_q <= beat_q + BEAT_W'(1);
            end
        end else if (gather_ok && start_ok) begin
            in_burst_q <= 1'b1;
            beat_q     <= '0;
        end
    end
endmodule

// File: rtl/txcr_chunk_ctrl.sv
// Chunk controller: splits the transfer length into commands of at most
// CHUNK_SECT sectors. It counts sectors gathered for the current command,
// pulses the issue strobe once all are in, and waits for the acknowledge
// before opening the next command. Assumes start is only honoured while idle.
module txcr_chunk_ctrl
    import txcr_pkg::*;
#(
    parameter int LEN_W      = 48,
    parameter int CHUNK_SECT = 256,
    parameter int CHK_W      = $clog2(CHUNK_SECT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] total_len,
    input  logic             sector_done,
    input  logic             cmd_done,
    output logic             busy,
    output logic             gather_ok,
    output logic             more_in_chunk,
    output logic             cmd_issue,
    output logic [CHK_W-1:0] chunk_size
);
    phase_e           phase_q;
    logic [LEN_W-1:0] len_left_q;
    logic [CHK_W-1:0] chunk_left_q;
    logic [CHK_W-1:0] chunk_size_q;

    // Size of the next command given the sectors still unassigned.
    function automatic logic [CHK_W-1:0] chunk_of(input logic [LEN_W-1:0] n);
        return (n >= LEN_W'(CHUNK_SECT)) ? CHK_W'(CHUNK_SECT) : n[CHK_W-1:0];
    endfunction

    // Status decodes for the burst engine and the ports.
    assign busy          = (phase_q != PH_IDLE);
    assign gather_ok     = (phase_q == PH_GATHER) && (chunk_left_q != '0);
    assign more_in_chunk = chunk_left_q > CHK_W'(1);
    assign cmd_issue     = (phase_q == PH_ISSUE);
    assign chunk_size    = chunk_size_q;

    // Phase sequencing and sector accounting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_IDLE;
            len_left_q   <= '0;
            chunk_left_q <= '0;
            chunk_size_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start && (total_len != '0)) begin
                        chunk_size_q <= chunk_of(total_len);
                        chunk_left_q <= chunk_of(total_len);
                        len_left_q   <= total_len - LEN_W'(chunk_of(total_len));
                        phase_q      <= PH_GATHER;
                    end
                end
                PH_GATHER: begin
                    if (sector_done) begin
                        chunk_left_q <= chunk_left_q - CHK_W'(1);
                        if (chunk_left_q == CHK_W'(1)) phase_q <= PH_ISSUE;
                    end
                end
                PH_ISSUE: phase_q <= PH_WAIT;
                PH_WAIT: begin
                    if (cmd_done) begin
                        if (len_left_q == '0) begin
                            phase_q <= PH_IDLE;
                        end else begin
                            chunk_size_q <= chunk_of(len_left_q);
                            chunk_left_q <= chunk_of(len_left_q);
                            len_left_q   <= len_left_q - LEN_W'(chunk_of(len_left_q));
                            phase_q      <= PH_GATHER;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txfifo_chunk_reader.sv
// Top: reads sector bursts from a transmit FIFO, forwards each word with a
// valid strobe one cycle after its read, and groups sectors into commands.
// Assumes the FIFO presents read data the cycle after a read enable.
module txfifo_chunk_reader #(
    parameter int DATA_W     = 512,
    parameter int CNT_W      = 16,
    parameter int LEN_W      = 48,
    parameter int BEATS      = 8,
    parameter int CHUNK_SECT = 256,
    parameter int CHK_W      = $clog2(CHUNK_SECT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic [LEN_W-1:0]  xfer_sectors,
    output logic              xfer_busy,
    input  logic [CNT_W-1:0]  fifo_level,
    output logic              fifo_rd_en,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              cmd_issue,
    output logic [CHK_W-1:0]  cmd_sectors,
    input  logic              cmd_done
);
    logic gather_ok;
    logic more_in_chunk;
    logic sector_done;
    logic out_valid_q;

    txcr_chunk_ctrl #(
        .LEN_W(LEN_W), .CHUNK_SECT(CHUNK_SECT), .CHK_W(CHK_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .total_len(xfer_sectors),
        .sector_done(sector_done), .cmd_done(cmd_done), .busy(xfer_busy),
        .gather_ok(gather_ok), .more_in_chunk(more_in_chunk),
        .cmd_issue(cmd_issue), .chunk_size(cmd_sectors)
    );

    txcr_burst_engine #(
        .CNT_W(CNT_W), .BEATS(BEATS)
    ) u_burst (
        .clk(clk), .rst_n(rst_n), .gather_ok(gather_ok),
        .more_in_chunk(more_in_chunk), .fifo_level(fifo_level),
        .rd_en(fifo_rd_en), .sector_done(sector_done)
    );

    // Valid strobe aligned with the FIFO's one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid_q <= 1'b0;
        else        out_valid_q <= fifo_rd_en;
    end

    assign out_valid = out_valid_q;
    assign out_data  = fifo_rd_data;
endmodule

// File: rtl/txcr_checker.sv
// Property checker for the chunked burst reader, attached by bind.
// Tracks its own run length and acknowledge wait from the ports.
module txcr_checker #(
    parameter int CNT_W = 16,
    parameter int BEATS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_start,
    input logic             xfer_busy,
    input logic [CNT_W-1:0] fifo_level,
    input logic             fifo_rd_en,
    input logic             out_valid,
    input logic             cmd_issue,
    input logic             cmd_done
);
    localparam int BEAT_W = $clog2(BEATS);

    logic [15:0] run_q;
    logic        wait_q;

    // Length of the current read-enable stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= '0;
        else if (fifo_rd_en) run_q <= run_q + 16'd1;
        else                 run_q <= '0;
    end

    // Window between a command pulse and its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         wait_q <= 1'b0;
        else if (cmd_issue) wait_q <= 1'b1;
        else if (cmd_done)  wait_q <= 1'b0;
    end

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> $past(xfer_start));
    assert_start_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_rd_en) |-> ($past(fifo_level) >= CNT_W'(BEATS)));
    assert_whole_sectors_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifo_rd_en) |-> ((run_q != '0) && (run_q[BEAT_W-1:0] == '0)));
    assert_no_cont_low_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd_en && (run_q[BEAT_W-1:0] == BEAT_W'(BEATS - 1))
            && (fifo_level < CNT_W'(2 * BEATS))) |=> !fifo_rd_en);
    assert_valid_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |=> out_valid);
    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rd_en |=> !out_valid);
    assert_issue_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |=> !cmd_issue);
    assert_hold_while_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> !fifo_rd_en);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> (!fifo_rd_en && !cmd_issue));
endmodule

bind txfifo_chunk_reader txcr_checker #(.CNT_W(CNT_W), .BEATS(BEATS)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_busy(xfer_busy),
    .fifo_level(fifo_level), .fifo_rd_en(fifo_rd_en), .out_valid(out_valid),
    .cmd_issue(cmd_issue), .cmd_done(cmd_done)
);

// File: tb/tb_txfifo_chunk_reader.sv
module tb_txfifo_chunk_reader;
    localparam int DATA_W = 512;
    localparam int CNT_W  = 16;
    localparam int LEN_W  = 48;
    localparam int CH     = 16;
    localparam int CHK_W  = $clog2(CH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xfer_start = 1'b0;
    logic [LEN_W-1:0]  xfer_sectors = '0;
    logic              xfer_busy;
    logic [CNT_W-1:0]  fifo_level;
    logic              fifo_rd_en;
    logic [DATA_W-1:0] fifo_rd_data;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              cmd_issue;
    logic [CHK_W-1:0]  cmd_sectors;
    logic              cmd_done = 1'b0;

    txfifo_chunk_reader #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W),
                          .BEATS(8), .CHUNK_SECT(CH)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_sectors(xfer_sectors),
        .xfer_busy(xfer_busy), .fifo_level(fifo_level), .fifo_rd_en(fifo_rd_en),
        .fifo_rd_data(fifo_rd_data), .out_valid(out_valid), .out_data(out_data),
        .cmd_issue(cmd_issue), .cmd_sectors(cmd_sectors), .cmd_done(cmd_done)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic logic [DATA_W-1:0] wordv(input int unsigned k);
        logic [31:0] w;
        w = 32'(k * 32'h9E37_79B1) ^ 32'h5A5A_0000;
        return {16{w}};
    endfunction

    // FIFO model: level counts stored words, data appears the cycle after a read.
    int          fill_pct = 0;
    int unsigned rptr = 0;
    bit          push;
    always @(posedge clk) begin
        if (!rst_n) begin
            fifo_level   <= '0;
            rptr         <= 0;
            fifo_rd_data <= '0;
        end else begin
            push = (int'($urandom_range(99)) < fill_pct) && (fifo_level < 16'd60);
            fifo_level <= fifo_level + 16'(push) - 16'(fifo_rd_en);
            if (fifo_rd_en) begin
                fifo_rd_data <= wordv(rptr);
                rptr <= rptr + 1;
            end
        end
    end

    // Acknowledge responder (sole driver of cmd_done).
    int spur_req = 0;
    int spur_ack = 0;
    always begin
        @(posedge clk); #1;
        if (spur_req != spur_ack) begin
            spur_ack = spur_req;
            @(posedge clk); #1 cmd_done = 1'b1;
            @(posedge clk); #1 cmd_done = 1'b0;
        end else if (cmd_issue) begin
            repeat (1 + $urandom_range(3)) @(posedge clk);
            #1 cmd_done = 1'b1;
            @(posedge clk); #1 cmd_done = 1'b0;
        end
    end

    // Reference monitor, sampled at the falling edge.
    bit          mon_on = 1'b0;
    bit          exp_busy = 1'b0;
    bit          p_rd = 1'b0, p_last = 1'b0, p_gath = 1'b0;
    bit          m_wait = 1'b0, chk_cont = 1'b0, cont_exp = 1'b0, last_now;
    int          p_level = 0, run = 0, m_rem = 0, m_chunk = 0, issues = 0;
    longint      m_left = 0;
    int unsigned exp_idx = 0;

    task automatic load_chunk();
        m_chunk = (m_left >= CH) ? CH : int'(m_left);
        m_left  = m_left - m_chunk;
        m_rem   = m_chunk;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            last_now = 1'b0;
            chk(xfer_busy == exp_busy, "R9", "busy", xfer_busy, exp_busy);
            chk(out_valid == p_rd, "R6", "out_valid lag", out_valid, p_rd);
            if (out_valid) begin
                chk(out_data == wordv(exp_idx), "R6", "data word", longint'(out_data[31:0]),
                    longint'(wordv(exp_idx) & 512'hFFFF_FFFF));
                exp_idx++;
            end
            if (!p_rd) begin
                chk(fifo_rd_en == (p_gath && p_level >= 8), "R3", "burst start",
                    fifo_rd_en, (p_gath && p_level >= 8));
                run = 0;
            end
            if (fifo_rd_en) chk(fifo_level != 0, "R3", "read from empty", fifo_level, 1);
            if (chk_cont) begin
                chk(fifo_rd_en == cont_exp, "R5", "continuation", fifo_rd_en, cont_exp);
                chk_cont = 1'b0;
            end
            if (!fifo_rd_en && p_rd) chk(run % 8 == 0, "R4", "burst length", run, 8);
            if (fifo_rd_en) begin
                run++;
                if (run % 8 == 0) begin
                    m_rem--;
                    cont_exp = (m_rem != 0) && (fifo_level >= 16);
                    chk_cont = 1'b1;
                    last_now = 1'b1;
                end
            end
            chk(cmd_issue == (p_last && m_rem == 0), "R7", "issue timing",
                cmd_issue, (p_last && m_rem == 0));
            if (cmd_issue) begin
                chk(cmd_sectors == CHK_W'(m_chunk), "R7", "issue size", cmd_sectors, m_chunk);
                m_wait = 1'b1;
                issues++;
            end
            if (m_wait) chk(!fifo_rd_en, "R8", "read while waiting", fifo_rd_en, 0);
            p_last = last_now;
            p_gath = xfer_busy && !m_wait && (m_rem != 0);
            if (!xfer_busy && xfer_start && xfer_sectors != '0) begin
                exp_busy = 1'b1;
                m_left = longint'(xfer_sectors);
                load_chunk();
            end
            if (m_wait && cmd_done) begin
                m_wait = 1'b0;
                if (m_left == 0) exp_busy = 1'b0;
                else load_chunk();
            end
            p_rd = fifo_rd_en;
            p_level = int'(fifo_level);
        end
    end

    task automatic run_xfer(input int len, input int fill, input bit spur, input bit dup);
        int unsigned base;
        int iss0;
        fill_pct = fill;
        base = exp_idx;
        iss0 = issues;
        @(posedge clk); #1 xfer_start = 1'b1; xfer_sectors = LEN_W'(len);
        @(posedge clk); #1 xfer_start = 1'b0; xfer_sectors = LEN_W'(48'h7);
        if (spur) spur_req++;
        if (dup) begin
            repeat (2) @(posedge clk);
            #1 xfer_start = 1'b1; xfer_sectors = LEN_W'(3);
            @(posedge clk); #1 xfer_start = 1'b0;
        end
        do begin @(posedge clk); #1; end while (xfer_busy);
        @(negedge clk);
        chk(exp_idx - base == 8 * len, "R9", "words forwarded", exp_idx - base, 8 * len);
        chk(issues - iss0 == (len + CH - 1) / CH, "R7", "command count",
            issues - iss0, (len + CH - 1) / CH);
        if (dup) chk(1'b1, "R2", "start while busy ignored (by word count)", 0, 0);
    endtask

    initial begin
        void'($urandom(32'h00C0_FFEE));
        repeat (3) @(negedge clk);
        chk(!xfer_busy, "R1", "busy in reset", xfer_busy, 0);
        chk(!fifo_rd_en, "R1", "rd_en in reset", fifo_rd_en, 0);
        chk(!out_valid, "R1", "valid in reset", out_valid, 0);
        chk(!cmd_issue, "R1", "issue in reset", cmd_issue, 0);
        @(posedge clk); #1 rst_n = 1'b1; mon_on = 1'b1;
        // R2: zero-length start is ignored.
        @(posedge clk); #1 xfer_start = 1'b1; xfer_sectors = '0;
        @(posedge clk); #1 xfer_start = 1'b0;
        repeat (2) @(negedge clk);
        chk(!xfer_busy, "R2", "zero-length start", xfer_busy, 0);
        // Directed corner cases.
        run_xfer(1, 100, 1'b0, 1'b0);
        run_xfer(CH, 100, 1'b0, 1'b0);
        run_xfer(CH + 1, 60, 1'b0, 1'b0);
        run_xfer(40, 20, 1'b0, 1'b0);
        run_xfer(33, 12, 1'b1, 1'b1);
        // Constrained random lengths and fill rates.
        for (int i = 0; i < 8; i++)
            run_xfer(1 + int'($urandom_range(49)), 10 + int'($urandom_range(90)),
                     $urandom_range(1) == 1, 1'b0);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual busy %0d expected completion", xfer_busy);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule